// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer with Shared Output Pin

The block holds two independent down-counting timers. Each one has a 6-bit prescaler in front of an 8-bit counter. Both stages divide the system clock by exactly the value loaded into them, and a loaded zero stands for the largest possible divisor. At each terminal count a timer raises a one-clock end-of-count pulse and flips its own toggle flip-flop. After that it either reloads and keeps running (continuous mode) or stops (single-shot mode).

Software sets up the block through a write-only register port made of an address, data and a strobe. The control register can also be read back on a dedicated read bus. A 2-bit source selector in the control register picks what drives a shared output pin:

- nothing,
- timer 0's toggle,
- timer 1's toggle, or
- the raw system clock.

A separate port-mode bit decides whether the pin belongs to the timer at all. When it does not, the pin is released to its alternate function and the timer drives it low.

Top module: `dual_div_timer`

## Requirements
- R1: With prescaler value p and counter value c, a running continuous timer raises `eoc_o[i]` every p*c clocks. The first pulse appears p*c clocks after the load edge, and there is no gap or extra cycle at reload.
- R2: A counter value of 1 gives a period of one prescaler tick. A counter value of 0 gives 256 prescaler ticks.
- R3: A prescaler value of 0 divides by 64.
- R4: With the continuous bit (bit 0 of the prescaler register) clear, a timer gives exactly one end-of-count pulse after a load and then stays silent until it is loaded again.
- R5: Writing the control register (address 0) with bit 0 set loads timer 0 from its reload registers, and bit 2 does the same for timer 1. The load takes effect on that clock edge. A control write with the load bit at 0 leaves a running or stopped timer untouched.
- R6: Control bit 1 enables timer 0 and bit 3 enables timer 1. While the enable is clear, the prescaler and counter hold their values, and counting resumes from them once the bit is set again.
- R7: Each end-of-count pulse lasts one clock and flips that timer's toggle flip-flop. The toggle resets to 0.
- R8: Control bits 7:6 select the pin source: 00 = low, 01 = timer 0 toggle, 10 = timer 1 toggle, 11 = system clock.
- R9: The port-mode register sits at address 5. When its bit 5 is 1, `tout_o` is held low and `tout_own_o` is 0. When bit 5 is 0, the selected source is driven and `tout_own_o` is 1.
- R10: `rd_data_o` shows the control register. Bits 7:6 and 3, 1 are stored, and the load bits 2, 0 and bits 5:4 read 0. The port-mode register does not appear on the read bus. All registers reset to 0.
- R11: Register addresses are as follows: timer i counter reload at 1+2i, and timer i prescaler at 2+2i. The prescaler register holds the value in bits 7:2 and the continuous bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Control register read-back |
| tout_o | output | 1 | Shared timer output pin |
| tout_own_o | output | 1 | 1 while the pin is configured as the timer output |
| eoc_o | output | 2 | One-clock end-of-count pulse per timer |

## Verification
A load or enable write is sampled at clock edge K. The end-of-count pulse of a timer loaded at K is then due in the cycle that follows edge K+p*c. An enable re-asserted at edge R lets counting restart at edge R+1. The bench's driver records K after every write, turns the requirements into exact cycle numbers and queues them. A monitor on the falling edge pops one entry per pulse and fails any pulse that arrives early, late or unannounced. The pin source and the control read-back change in the cycle of the write edge. They are checked half a cycle later, once in the high clock phase and once in the low phase, so the clock source can be distinguished from a constant level.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_TMR  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PORT = 3'd5;
  localparam int unsigned PORT_BIT = 5;
  localparam int unsigned CONT_BIT = 0;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_T0  = 2'b01,
    SRC_T1  = 2'b10,
    SRC_CLK = 2'b11
  } src_e;

  function automatic logic [ADDR_W-1:0] cnt_addr(input int unsigned i);
    return ADDR_W'(1 + 2 * i);
  endfunction

  function automatic logic [ADDR_W-1:0] pre_addr(input int unsigned i);
    return ADDR_W'(2 + 2 * i);
  endfunction
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output src_e                        sel_o,
  output logic [N_TMR-1:0]            en_o,
  output logic [N_TMR-1:0]            load_o,
  output logic [N_TMR-1:0]            cont_o,
  output logic [N_TMR-1:0][CNT_W-1:0] cnt_rld_o,
  output logic [N_TMR-1:0][PRE_W-1:0] pre_rld_o,
  output logic                        pm_o,
  output logic [DATA_W-1:0]           rd_data_o
);
  localparam int unsigned PRE_LSB = DATA_W - PRE_W;

  logic ctrl_we;
  logic [1:0] sel_q;

  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 2'b00;
      pm_o  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) sel_q <= wr_data_i[7:6];
      if (wr_addr_i == A_PORT) pm_o  <= wr_data_i[PORT_BIT];
    end
  end

  assign sel_o = src_e'(sel_q);

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    // load is a write-one strobe, never stored
    assign load_o[g] = ctrl_we && wr_data_i[2*g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]      <= 1'b0;
        cont_o[g]    <= 1'b0;
        cnt_rld_o[g] <= '0;
        pre_rld_o[g] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == A_CTRL) en_o[g] <= wr_data_i[2*g+1];
        if (wr_addr_i == cnt_addr(g)) cnt_rld_o[g] <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == pre_addr(g)) begin
          pre_rld_o[g] <= wr_data_i[DATA_W-1:PRE_LSB];
          cont_o[g]    <= wr_data_i[CONT_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_data_o      = '0;
    rd_data_o[7:6] = sel_q;
    for (int i = 0; i < int'(N_TMR); i++) rd_data_o[2*i+1] = en_o[i];
  end
endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] cnt_rld_i,
  input  logic [PRE_W-1:0] pre_rld_i,
  output logic             eoc_o,
  output logic             tgl_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;
  logic             run;
  logic             tick;
  logic             term;

  // zero wraps to all-ones on decrement, so 0 divides by 2**W
  assign run  = en_i && arm_q;
  assign tick = run && (pre_q == PRE_W'(1));
  assign term = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (load_i) begin
      pre_q <= pre_rld_i;
      cnt_q <= cnt_rld_i;
      arm_q <= 1'b1;
    end else if (run) begin
      if (tick) begin
        pre_q <= pre_rld_i;
        if (term) begin
          cnt_q <= cnt_rld_i;
          arm_q <= cont_i;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_o <= 1'b0;
      tgl_o <= 1'b0;
    end else begin
      eoc_o <= term && !load_i;
      if (term && !load_i) tgl_o <= !tgl_o;
    end
  end

  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(cnt_rld_i)) && (pre_q == $past(pre_rld_i))); // R5
  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q) && $stable(pre_q)); // R6
  AST_TOGGLE_ON_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (tgl_o != $past(tgl_o))); // R7
  AST_TOGGLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> $stable(tgl_o)); // R7
endmodule

// File: rtl/dtmr_outmux.sv
module dtmr_outmux
  import dtmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             sel_i,
  input  logic             pm_i,
  input  logic [N_TMR-1:0] tgl_i,
  output logic             tout_o,
  output logic             tout_own_o
);
  logic src;

  always_comb begin
    unique case (sel_i)
      SRC_T0:  src = tgl_i[0];
      SRC_T1:  src = tgl_i[1];
      SRC_CLK: src = clk_i;
      default: src = 1'b0;
    endcase
  end

  assign tout_own_o = !pm_i;
  assign tout_o     = tout_own_o && src;

  AST_SEL_OFF_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_OFF) |-> !tout_o); // R8
  AST_PIN_RELEASED_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pm_i |-> !tout_o); // R9
endmodule

// File: rtl/dual_div_timer.sv
module dual_div_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic              tout_o,
  output logic              tout_own_o,
  output logic [1:0]        eoc_o
);
  src_e                        sel;
  logic                        pm;
  logic [N_TMR-1:0]            en, load, cont, tgl;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_rld;
  logic [N_TMR-1:0][PRE_W-1:0] pre_rld;

  dtmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel),
    .en_o      (en),
    .load_o    (load),
    .cont_o    (cont),
    .cnt_rld_o (cnt_rld),
    .pre_rld_o (pre_rld),
    .pm_o      (pm),
    .rd_data_o (rd_data_o)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_unit
    dtmr_unit #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[g]),
      .en_i      (en[g]),
      .cont_i    (cont[g]),
      .cnt_rld_i (cnt_rld[g]),
      .pre_rld_i (pre_rld[g]),
      .eoc_o     (eoc_o[g]),
      .tgl_o     (tgl[g])
    );
  end

  dtmr_outmux u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .pm_i       (pm),
    .tgl_i      (tgl),
    .tout_o     (tout_o),
    .tout_own_o (tout_own_o)
  );
endmodule

// File: tb/sim_dual_div_timer.sv
`timescale 1ns/1ps
module sim_dual_div_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tout, tout_own;
  logic [1:0] eoc;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_k = 0;
  int q0[$];
  int q1[$];
  int n_ev[2] = '{0, 0};
  logic [1:0] sel_m = 2'b00;
  logic       pm_m = 1'b0;
  logic [1:0] tgl_m = 2'b00;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_div_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .tout_o(tout),
    .tout_own_o(tout_own), .eoc_o(eoc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    last_k = cyc;
    if (a == 3'd0) sel_m = d[7:6];
    if (a == 3'd5) pm_m = d[5];
  endtask

  task automatic push(input int i, input int t);
    if (i == 0) q0.push_back(t); else q1.push_back(t);
  endtask

  task automatic drain(input int i);
    while ((i == 0) ? (q0.size() != 0) : (q1.size() != 0)) @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops one scheduled event per observed pulse (R1, R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        if (eoc[i]) begin
          int exp_t;
          n_ev[i]++;
          tgl_m[i] = ~tgl_m[i];
          exp_t = -1;
          if (i == 0 && q0.size() != 0) exp_t = q0.pop_front();
          if (i == 1 && q1.size() != 0) exp_t = q1.pop_front();
          chk($sformatf("R1 eoc timer%0d cycle", i), cyc, exp_t);
          if (!pm_m && sel_m == 2'(i + 1))
            chk($sformatf("R7 tout toggle timer%0d", i), int'(tout), int'(tgl_m[i]));
        end
      end
    end
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, d, r, base;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rd_data", rd_data, 0);
    chk("R9 reset own", tout_own, 1);
    chk("R8 reset tout", tout, 0);
    chk("R7 reset eoc", eoc, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 continuous pre=1 cnt=3, sel T0
    wr(3'd1, 8'd3);
    wr(3'd2, 8'h05);
    wr(3'd0, 8'h43);
    push(0, last_k + 3); push(0, last_k + 6); push(0, last_k + 9);
    chk("R10 load bit reads 0", rd_data, 8'h42);
    drain(0);
    wr(3'd0, 8'h40);

    // R5 control write without load mid-run changes nothing
    wr(3'd1, 8'd5);
    wr(3'd0, 8'h43);
    push(0, last_k + 5); push(0, last_k + 10); push(0, last_k + 15);
    wr(3'd0, 8'h42);
    drain(0);
    wr(3'd0, 8'h40);

    // R2 minimum: cnt=1 pre=1 single shot
    wr(3'd1, 8'd1);
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h43);
    push(0, last_k + 1);
    idle(6);

    // R2 maximum: cnt=0 -> 256 ticks, single shot, then R4 silence
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h43);
    push(0, last_k + 256);
    drain(0);
    base = n_ev[0];
    wr(3'd0, 8'h42);  // R5: no load bit, no restart
    idle(300);
    chk("R4 single shot stays silent", n_ev[0], base);

    // R3 prescaler 0 -> 64, cnt=2 single shot
    wr(3'd1, 8'd2);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h43);
    push(0, last_k + 128);
    drain(0);
    wr(3'd0, 8'h40);

    // R6 timer 1: load while disabled, then enable, hold, resume; sel T1
    wr(3'd3, 8'd2);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h84);
    idle(10);
    wr(3'd0, 8'h88);
    e = last_k + 4;
    push(1, e);
    drain(1);
    wr(3'd0, 8'h80);
    d = last_k;
    base = n_ev[1];
    idle(20);
    chk("R6 disabled timer holds", n_ev[1], base);
    wr(3'd0, 8'h88);
    r = last_k;
    push(1, r + 4 - (d - e));
    push(1, r + 8 - (d - e));
    drain(1);
    wr(3'd0, 8'h80);

    // R8 source off
    wr(3'd0, 8'h00);
    @(posedge clk); #2; chk("R8 off high phase", tout, 0);
    @(negedge clk); #2; chk("R8 off low phase", tout, 0);
    // R8 clock source
    wr(3'd0, 8'hC0);
    chk("R10 readback sel", rd_data, 8'hC0);
    @(posedge clk); #2; chk("R8 clk high phase", tout, 1);
    @(negedge clk); #2; chk("R8 clk low phase", tout, 0);
    // R9 pin released
    wr(3'd5, 8'h20);
    chk("R9 own released", tout_own, 0);
    chk("R10 port mode not readable", rd_data, 8'hC0);
    @(posedge clk); #2; chk("R9 released high phase", tout, 0);
    @(negedge clk); #2; chk("R9 released low phase", tout, 0);
    wr(3'd5, 8'h00);
    chk("R9 own restored", tout_own, 1);
    @(posedge clk); #2; chk("R9 restored high phase", tout, 1);

    // R11 prescaler field position: pre=3 (bits 7:2), cnt=2, continuous
    wr(3'd1, 8'd2);
    wr(3'd2, 8'h0D);
    wr(3'd0, 8'h43);
    push(0, last_k + 6); push(0, last_k + 12);
    drain(0);
    wr(3'd0, 8'h40);
    idle(20);

    chk("R1 timer0 queue empty", q0.size(), 0);
    chk("R1 timer1 queue empty", q1.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule